// File: doc/BRIEF.md
# UART Register Front End

This block is the memory-mapped register file of a UART, covering a 4 KB window of 1024 word slots. It decodes word-addressed read and write accesses from a simple single-cycle bus. It stores the configuration fields: baud divisors, line control, control, FIFO trigger level, infrared low-power divisor, DMA control and interrupt mask. It returns status from the neighbouring FIFO and interrupt logic, and it serves a fixed set of identification bytes at the top of the window.

Accesses to some slots have side effects. A read of the data slot sends a one-cycle pop strobe to the receive FIFO. A write of the data slot sends a one-cycle push strobe and the character to the transmit FIFO. A write to the receive-status slot clears the latched error bits. A change of the FIFO-enable bit requests a FIFO flush. The raw interrupt status is held here: the interrupt sources set its bits, and a write to the clear slot removes them.

Read data is registered. It appears on the cycle after the access and holds until the next read. All strobes are likewise one cycle after the access. The write data port carries only the low 16 bits, because every writable field fits in them. There are no byte enables.

Top module: `uart_regfile`

## Requirements
- R1: After reset, every word slot reads as follows. Slot 12 (control) reads 0x300 and slot 13 (FIFO level) reads 0x12. Slot 6 (flags) reflects the status inputs, slot 0 reads the receive head, and slots 1, 8, 9, 10, 11, 14, 15, 16 and 18 read 0. Slots 0x3F8..0x3FF read the identification bytes (R10), and every other slot reads 0.
- R2: The configuration slots store and read back their widths, zero-extended: 8 = low-power divisor (8 bits), 9 = integer divisor (16), 10 = fractional divisor (6), 11 = line control (8), 12 = control (16), 13 = FIFO level (6), 14 = mask (11), 18 = DMA control (3). Each is driven on its output port.
- R3: A read of slot 0 returns rx_head in bits 11:0, with bits 11:8 being the error flags. When rx_empty is low, the read raises rx_pop for exactly one cycle and latches rx_head[11:8] into the receive-status register, which slot 1 reads back. When rx_empty is high, there is no pop.
- R4: A write of slot 0 raises tx_push for exactly one cycle with tx_data equal to write data bits 7:0, and sets raw status bit 5.
- R5: Any write to slot 1 clears the receive-status register.
- R6: Slot 6 reads bit 7 = tx_empty, bit 6 = rx_full, bit 5 = tx_full, bit 4 = rx_empty, and 0 in all other bits. Writes to slot 6 change nothing.
- R7: Raw status (slot 15, 11 bits) ORs in int_set every cycle. A write to slot 17 clears the bits written as 1, and a set in the same cycle wins. Slot 16 reads raw AND mask, and irq is high when that value is nonzero. Slot 17 reads 0.
- R8: A line-control write that flips bit 4 raises fifo_flush for one cycle. A write that leaves bit 4 unchanged does not. fifo_en follows bit 4 and send_break follows bit 0.
- R9: baud_div equals integer divisor × 64 + fractional divisor. baud_zero is high exactly when the integer divisor is 0.
- R10: Slots 0x3F8..0x3FF (byte offsets 0xFE0..0xFFC) read 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word index within the 4 KB window |
| bus_wdata | input | 16 | Write data (upper half of the word is reserved) |
| bus_rdata | output | 32 | Registered read data |
| rx_head | input | 12 | Receive FIFO head: error flags 11:8, character 7:0 |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_full | input | 1 | Receive FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| int_set | input | 11 | Interrupt source set pulses |
| rx_pop | output | 1 | One-cycle receive pop strobe |
| tx_push | output | 1 | One-cycle transmit push strobe |
| tx_data | output | 8 | Character to push |
| fifo_flush | output | 1 | One-cycle FIFO flush request |
| fifo_en | output | 1 | FIFO enable (line control bit 4) |
| send_break | output | 1 | Break request (line control bit 0) |
| ctrl | output | 16 | Control register |
| fifo_level | output | 6 | FIFO trigger level select |
| irda_lp | output | 8 | Low-power divisor |
| dma_ctrl | output | 3 | DMA control |
| baud_div | output | 22 | Combined baud divisor |
| baud_zero | output | 1 | Integer divisor is zero |
| irq | output | 1 | Any enabled interrupt pending |

## Verification
The decode is tried with a read of all 1024 word slots straight after reset, compared against values the bench computes per slot. This tells mapped slots from holes and each identification byte from its neighbours. The baud divisor is swept through all 64 fractional values at four integer values, including zero, which separates the combination arithmetic from the zero detect. The flag slot is read with all 16 status input combinations, which exposes any swapped bit. The side-effect slots are driven with an empty and a non-empty receive FIFO, with FIFO-enable flips against non-flips, and with a set and clear of the same status bit in one cycle.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 6,
  parameter int INT_W  = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_en,
  input  logic                     bus_we,
  input  logic [9:0]               bus_addr,
  input  logic [15:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [11:0]              rx_head,
  input  logic                     rx_empty,
  input  logic                     rx_full,
  input  logic                     tx_empty,
  input  logic                     tx_full,
  input  logic [INT_W-1:0]         int_set,
  output logic                     rx_pop,
  output logic                     tx_push,
  output logic [7:0]               tx_data,
  output logic                     fifo_flush,
  output logic                     fifo_en,
  output logic                     send_break,
  output logic [15:0]              ctrl,
  output logic [5:0]               fifo_level,
  output logic [7:0]               irda_lp,
  output logic [2:0]               dma_ctrl,
  output logic [DIV_W+FRAC_W-1:0]  baud_div,
  output logic                     baud_zero,
  output logic                     irq
);

  localparam int TX_BIT = 5;

  logic             wr, rd;
  logic [3:0]       rsr_q;
  logic [7:0]       lcr_q;
  logic [DIV_W-1:0] ibrd_q;
  logic [FRAC_W-1:0] fbrd_q;
  logic [INT_W-1:0] mask_q, raw_q, clr_v;
  logic [31:0]      rmux;
  logic             take_rx, put_tx;

  assign wr      = bus_en &  bus_we;
  assign rd      = bus_en & ~bus_we;
  assign take_rx = rd && bus_addr == 10'd0 && !rx_empty;
  assign put_tx  = wr && bus_addr == 10'd0;
  assign clr_v   = (wr && bus_addr == 10'd17) ? bus_wdata[INT_W-1:0] : '0;

  assign fifo_en    = lcr_q[4];
  assign send_break = lcr_q[0];
  assign baud_div   = {ibrd_q, fbrd_q};
  assign baud_zero  = (ibrd_q == '0);
  assign irq        = |(raw_q & mask_q);

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0: id_byte = 8'h11;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  always_comb begin
    rmux = '0;
    if (bus_addr[9:3] == 7'h7F) rmux = {24'd0, id_byte(bus_addr[2:0])};
    else case (bus_addr)
      10'd0:  rmux = {20'd0, rx_head};
      10'd1:  rmux = {28'd0, rsr_q};
      10'd6:  rmux = {24'd0, tx_empty, rx_full, tx_full, rx_empty, 4'd0};
      10'd8:  rmux = 32'(irda_lp);
      10'd9:  rmux = 32'(ibrd_q);
      10'd10: rmux = 32'(fbrd_q);
      10'd11: rmux = 32'(lcr_q);
      10'd12: rmux = 32'(ctrl);
      10'd13: rmux = 32'(fifo_level);
      10'd14: rmux = 32'(mask_q);
      10'd15: rmux = 32'(raw_q);
      10'd16: rmux = 32'(raw_q & mask_q);
      10'd18: rmux = 32'(dma_ctrl);
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      rsr_q      <= '0;
      lcr_q      <= '0;
      ibrd_q     <= '0;
      fbrd_q     <= '0;
      mask_q     <= '0;
      raw_q      <= '0;
      ctrl       <= 16'h0300;
      fifo_level <= 6'h12;
      irda_lp    <= '0;
      dma_ctrl   <= '0;
      rx_pop     <= 1'b0;
      tx_push    <= 1'b0;
      tx_data    <= '0;
      fifo_flush <= 1'b0;
    end else begin
      rx_pop     <= take_rx;
      tx_push    <= put_tx;
      fifo_flush <= wr && bus_addr == 10'd11 && (bus_wdata[4] != lcr_q[4]);
      raw_q      <= (raw_q & ~clr_v) | int_set | (put_tx ? INT_W'(1 << TX_BIT) : '0);
      if (rd) bus_rdata <= rmux;
      if (put_tx) tx_data <= bus_wdata[7:0];
      if (wr && bus_addr == 10'd1) rsr_q <= '0;
      else if (take_rx)            rsr_q <= rx_head[11:8];
      if (wr) case (bus_addr)
        10'd8:  irda_lp    <= bus_wdata[7:0];
        10'd9:  ibrd_q     <= bus_wdata[DIV_W-1:0];
        10'd10: fbrd_q     <= bus_wdata[FRAC_W-1:0];
        10'd11: lcr_q      <= bus_wdata[7:0];
        10'd12: ctrl       <= bus_wdata;
        10'd13: fifo_level <= bus_wdata[5:0];
        10'd14: mask_q     <= bus_wdata[INT_W-1:0];
        10'd18: dma_ctrl   <= bus_wdata[2:0];
        default: ;
      endcase
    end
  end

  assert_pop_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> $past(bus_en && !bus_we && bus_addr == 10'd0 && !rx_empty));

  assert_push_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> $past(bus_en && bus_we && bus_addr == 10'd0));

  assert_rsr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_en && bus_we && bus_addr == 10'd1) |-> rsr_q == 4'd0);

  assert_raw_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_en && bus_we && bus_addr == 10'd17) |-> ((raw_q & $past(raw_q)) == $past(raw_q)));

  assert_flush_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> (lcr_q[4] != $past(lcr_q[4])));

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_en && bus_we && bus_addr == 10'd12) |-> $stable(ctrl));

endmodule

// File: tb/sim_uart_regfile.sv
module sim_uart_regfile;
  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [9:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] rx_head = '0;
  logic rx_empty = 1, rx_full = 0, tx_empty = 1, tx_full = 0;
  logic [10:0] int_set = '0;
  logic rx_pop, tx_push, fifo_flush, fifo_en, send_break, baud_zero, irq;
  logic [7:0] tx_data, irda_lp;
  logic [15:0] ctrl;
  logic [5:0] fifo_level;
  logic [2:0] dma_ctrl;
  logic [21:0] baud_div;
  int total = 0, fails = 0;
  logic done = 0;

  always #4 clk = ~clk;

  uart_regfile u0 (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  function automatic logic [31:0] rst_exp(input int w);
    logic [7:0] ids [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (w >= 'h3F8) return {24'd0, ids[w - 'h3F8]};
    if (w == 6) return 32'h90;
    if (w == 12) return 32'h300;
    if (w == 13) return 32'h12;
    return 32'd0;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 and R10: full window after reset
    for (int w = 0; w < 1024; w++) begin
      acc(0, w[9:0], 0);
      chk($sformatf("R1/R10 slot %0d", w), bus_rdata, rst_exp(w));
    end
    chk("R1 ctrl port", {16'd0, ctrl}, 32'h300);
    chk("R1 level port", {26'd0, fifo_level}, 32'h12);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 write/readback
    begin
      int slots [8] = '{8, 9, 10, 11, 12, 13, 14, 18};
      int widths [8] = '{8, 16, 6, 8, 16, 6, 11, 3};
      for (int i = 0; i < 8; i++) begin
        acc(1, slots[i][9:0], 16'hFFFF);
        acc(0, slots[i][9:0], 0);
        chk($sformatf("R2 slot %0d ones", slots[i]), bus_rdata, (32'd1 << widths[i]) - 1);
        acc(1, slots[i][9:0], 16'hA5A5);
        acc(0, slots[i][9:0], 0);
        chk($sformatf("R2 slot %0d pattern", slots[i]), bus_rdata, 32'hA5A5 & ((32'd1 << widths[i]) - 1));
      end
      chk("R2 ctrl port", {16'd0, ctrl}, 32'hA5A5);
      chk("R2 irda port", {24'd0, irda_lp}, 32'hA5);
      chk("R2 dma port", {29'd0, dma_ctrl}, 32'h5);
      chk("R2 level port", {26'd0, fifo_level}, 32'h25);
    end

    // R9 baud sweep
    begin
      int ivals [4] = '{0, 1, 'h1234, 'hFFFF};
      for (int i = 0; i < 4; i++) begin
        acc(1, 9, ivals[i][15:0]);
        for (int f = 0; f < 64; f++) begin
          acc(1, 10, f[15:0]);
          chk("R9 baud_div", {10'd0, baud_div}, ivals[i] * 64 + f);
          chk("R9 baud_zero", {31'd0, baud_zero}, ivals[i] == 0);
        end
      end
    end

    // R3 data read, non-empty
    rx_head = 12'hA5C; rx_empty = 0;
    acc(0, 0, 0);
    chk("R3 rdata", bus_rdata, 32'hA5C);
    chk("R3 pop high", {31'd0, rx_pop}, 1);
    @(negedge clk);
    chk("R3 pop one cycle", {31'd0, rx_pop}, 0);
    rx_head = 12'h3C1;
    acc(0, 1, 0);
    chk("R3 rsr latched", bus_rdata, 32'hA);
    // R5
    acc(1, 1, 16'h0);
    acc(0, 1, 0);
    chk("R5 rsr cleared", bus_rdata, 0);
    // R3 empty: no pop, no latch
    rx_empty = 1;
    acc(0, 0, 0);
    chk("R3 empty rdata", bus_rdata, 32'h3C1);
    chk("R3 empty no pop", {31'd0, rx_pop}, 0);
    acc(0, 1, 0);
    chk("R3 empty no latch", bus_rdata, 0);

    // R7 clear pending first
    acc(1, 17, 16'h07FF);
    acc(0, 15, 0);
    chk("R7 raw cleared", bus_rdata, 0);

    // R4 data write
    acc(1, 0, 16'h01C3);
    chk("R4 push high", {31'd0, tx_push}, 1);
    chk("R4 tx_data", {24'd0, tx_data}, 32'hC3);
    @(negedge clk);
    chk("R4 push one cycle", {31'd0, tx_push}, 0);
    acc(0, 15, 0);
    chk("R4 raw tx bit", bus_rdata, 32'h20);

    // R7 set/clear/mask
    @(negedge clk); int_set = 11'h401; @(negedge clk); int_set = 0;
    acc(0, 15, 0);
    chk("R7 raw set", bus_rdata, 32'h421);
    acc(1, 14, 16'h0000);
    chk("R7 irq masked off", {31'd0, irq}, 0);
    acc(1, 14, 16'h0400);
    chk("R7 irq", {31'd0, irq}, 1);
    acc(0, 16, 0);
    chk("R7 masked", bus_rdata, 32'h400);
    acc(1, 17, 16'h0001);
    acc(0, 15, 0);
    chk("R7 partial clear", bus_rdata, 32'h420);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 17; bus_wdata = 16'h0400; int_set = 11'h400;
    @(negedge clk);
    bus_en = 0; bus_we = 0; int_set = 0;
    acc(0, 15, 0);
    chk("R7 set wins", bus_rdata, 32'h420);
    acc(0, 17, 0);
    chk("R7 clear slot reads 0", bus_rdata, 0);

    // R6 flags
    for (int k = 0; k < 16; k++) begin
      {tx_empty, rx_full, tx_full, rx_empty} = k[3:0];
      acc(0, 6, 0);
      chk("R6 flags", bus_rdata, k << 4);
    end
    acc(1, 6, 16'hFFFF);
    acc(0, 6, 0);
    chk("R6 write ignored", bus_rdata, 32'hF0);

    // R8 line control
    acc(1, 11, 16'h0000);
    @(negedge clk);
    acc(1, 11, 16'h0010);
    chk("R8 flush on flip", {31'd0, fifo_flush}, 1);
    chk("R8 fifo_en", {31'd0, fifo_en}, 1);
    @(negedge clk);
    chk("R8 flush one cycle", {31'd0, fifo_flush}, 0);
    acc(1, 11, 16'h0011);
    chk("R8 no flush", {31'd0, fifo_flush}, 0);
    chk("R8 break", {31'd0, send_break}, 1);
    acc(1, 11, 16'h0001);
    chk("R8 flush on clear", {31'd0, fifo_flush}, 1);
    chk("R8 fifo_en off", {31'd0, fifo_en}, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule